// File: doc/BRIEF.md
# Queue-Port Request Messaging Unit

This unit sits on the controller side of a host link. It gives the host a small 32-bit register window through which requests are exchanged as 32-bit tokens. Two of the addresses in the window are queue ports, and each one has a different meaning for reads and for writes. A read of the inbound port hands the host a free token from a free list. The free list holds controller-local buffer offsets and is filled with a fixed set of tokens at reset. A write to the inbound port posts a token to the controller. A read of the outbound port collects a completed token. A write to the outbound port gives a controller-local token back to the free list.

A token for a request that lives in host memory has bit 31 set. Its bits 30:0 hold the 32-byte-aligned bus address shifted right by five. Such a token belongs to the host, so it never enters the free list. A local processor interface removes posted tokens and pushes completion tokens. Commands that do not go through the queues use a message-register handshake: the host writes inbound message 0, and the controller signals completion by writing the identical value into outbound message 0. The unit also has a doorbell and interrupt status and mask registers in both directions.

Top module: `qpmu_top`

## Requirements
- R1: After reset the free list holds FREE_DEPTH tokens, TOK_BASE + i*TOK_STEP for i = 0 upward, in that order. The post and completion queues are empty, all status, mask, message and doorbell registers read 0, and h_irq and l_irq are low.
- R2: A host read (h_rd) of offset 0x40 removes the token at the head of the free list. The token appears on h_rdata in the cycle after the read.
- R3: A read of 0x40 while the free list is empty, or of 0x44 while the completion queue is empty, returns 0xFFFFFFFF and leaves the queue unchanged.
- R4: A host write to 0x40 appends the written token to the post queue. l_ibox_valid and l_ibox_token show the oldest posted token, and l_ibox_pop removes it, in first-in first-out order.
- R5: l_cmpl_push appends l_cmpl_token to the completion queue. Host reads of 0x44 return the completion tokens in the order they were pushed.
- R6: A host write to 0x44 whose bit 31 is clear appends the token to the tail of the free list. A write to 0x44 with bit 31 set (a host-memory token, bit 31 = 1 and bits 30:0 = address >> 5) is discarded, and it does not set the overflow bit.
- R7: A write to any full queue (the post queue, the free list, or the completion queue) is dropped and sets the sticky overflow bit, bit 2 of outbound status (0x30).
- R8: Host writes to 0x10 and 0x14 load inbound messages 0 and 1 (l_imsg0, l_imsg1) and set inbound status bits 0 and 1. l_istat_clr clears those bits. l_omsg_we[k] loads outbound message k from l_omsg_data. The host reads outbound messages 0 and 1 at 0x18 and 0x1C, and a write of outbound message 0 sets outbound status bit 1.
- R9: Outbound status (0x30) has bit 0 = completion queue not empty (follows the queue), bit 1 = outbound message 0 written, and bit 2 = overflow. Writing 1 to bit 1 or bit 2 clears it. Bit 0 ignores writes.
- R10: h_irq is high when any outbound status bit is set whose outbound mask bit (0x34, 1 = masked) is clear.
- R11: A host write to 0x20 ORs its data into the doorbell (l_doorbell), and l_db_clr clears the selected bits. Inbound status (0x24) has bit 2 = doorbell non-zero and bit 3 = post queue not empty. l_irq is high when any inbound status bit is set whose inbound mask bit (0x28) is clear.
- R12: The registers at 0x10, 0x14, 0x18, 0x1C, 0x20, 0x24, 0x28, 0x30 and 0x34 read back their current values. Reads of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr | input | 1 | Host register write strobe |
| h_rd | input | 1 | Host register read strobe |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid the cycle after h_rd |
| h_irq | output | 1 | Outbound interrupt to the host |
| l_ibox_valid | output | 1 | Post queue holds a token |
| l_ibox_token | output | 32 | Oldest posted token |
| l_ibox_pop | input | 1 | Remove the oldest posted token |
| l_cmpl_push | input | 1 | Push a completion token |
| l_cmpl_token | input | 32 | Completion token |
| l_imsg0 | output | 32 | Inbound message 0 |
| l_imsg1 | output | 32 | Inbound message 1 |
| l_istat_clr | input | 2 | Clear inbound message-written status bits 1:0 |
| l_omsg_we | input | 2 | Write enables for outbound messages 1:0 |
| l_omsg_data | input | 32 | Outbound message write data |
| l_doorbell | output | 32 | Inbound doorbell bits |
| l_db_clr | input | 32 | Doorbell bits to clear |
| l_irq | output | 1 | Inbound interrupt to the local processor |

## Verification
The hardest states to reach from the ports are the full queues. The free list starts full at reset, so a free-list overflow needs the host to return a token that was never taken out. The bench first empties the list through the inbound port, refills it with eight write-backs, and then writes one more. That ninth write must be dropped and must raise the overflow bit and h_irq. Next to it, a host-memory token written to the outbound port must leave the empty free list still empty, and the bench confirms this by checking that an inbound read still returns 0xFFFFFFFF.

// File: rtl/qpmu_pkg.sv
// Package: shared widths, register offsets and status bit positions for the
// queue-port messaging unit. Assumes a byte-addressed 32-bit register window.
package qpmu_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_IMSG0 = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_IMSG1 = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_OMSG0 = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_OMSG1 = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_DBELL = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_ISTAT = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_IMASK = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_OSTAT = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_OMASK = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_INQ   = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_OUTQ  = 8'h44;

    localparam int OST_W      = 3;
    localparam int OST_NEMPTY = 0;
    localparam int OST_OMSG   = 1;
    localparam int OST_OVF    = 2;

    localparam int IST_W      = 4;
    localparam int IST_MSG0   = 0;
    localparam int IST_MSG1   = 1;
    localparam int IST_DBELL  = 2;
    localparam int IST_POST   = 3;

    localparam logic [DATA_W-1:0] EMPTY_TOKEN = '1;
    localparam int HOST_TOKEN_BIT = DATA_W - 1;
endpackage

// File: rtl/qpmu_fifo.sv
// Module: synchronous first-in first-out token store.
// Assumes one push and one pop port. A push to a full store and a pop from an
// empty store are ignored. With INIT_FULL set, reset loads every entry with
// INIT_BASE + i*INIT_STEP, so the store starts full.
module qpmu_fifo #(
    parameter int W         = 32,
    parameter int DEPTH     = 8,
    parameter bit INIT_FULL = 1'b0,
    parameter int INIT_BASE = 0,
    parameter int INIT_STEP = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign count   = cnt;

    // Storage: preload on reset, write on an accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= INIT_FULL ? W'(INIT_BASE + i * INIT_STEP) : '0;
            end
        end else if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= INIT_FULL ? CW'(DEPTH) : '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/qpmu_msgbox.sv
// Module: message registers, doorbell and inbound interrupt logic.
// Assumes the host writes inbound messages, the doorbell and the inbound mask,
// while the local side writes outbound messages and clears inbound events.
module qpmu_msgbox
    import qpmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_imsg0,
    input  logic              wr_imsg1,
    input  logic              wr_dbell,
    input  logic              wr_imask,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        istat_clr,
    input  logic [DATA_W-1:0] db_clr,
    input  logic [1:0]        omsg_we,
    input  logic [DATA_W-1:0] omsg_data,
    input  logic              post_nempty,
    output logic [DATA_W-1:0] imsg0,
    output logic [DATA_W-1:0] imsg1,
    output logic [DATA_W-1:0] omsg0,
    output logic [DATA_W-1:0] omsg1,
    output logic [DATA_W-1:0] dbell,
    output logic [IST_W-1:0]  istat,
    output logic [IST_W-1:0]  imask,
    output logic              irq
);
    logic [1:0] msg_new;

    // Inbound message registers, loaded by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imsg0 <= '0;
            imsg1 <= '0;
        end else begin
            if (wr_imsg0) imsg0 <= wdata;
            if (wr_imsg1) imsg1 <= wdata;
        end
    end

    // Outbound message registers, loaded by the local side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            omsg0 <= '0;
            omsg1 <= '0;
        end else begin
            if (omsg_we[0]) omsg0 <= omsg_data;
            if (omsg_we[1]) omsg1 <= omsg_data;
        end
    end

    // Message-written flags: a new write wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_new <= '0;
        end else begin
            msg_new[0] <= wr_imsg0 | (msg_new[0] & ~istat_clr[0]);
            msg_new[1] <= wr_imsg1 | (msg_new[1] & ~istat_clr[1]);
        end
    end

    // Doorbell: host bits are ORed in, local clears take effect first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbell <= '0;
        end else begin
            dbell <= (dbell & ~db_clr) | (wr_dbell ? wdata : '0);
        end
    end

    // Inbound interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask <= '0;
        end else if (wr_imask) begin
            imask <= wdata[IST_W-1:0];
        end
    end

    // Inbound status assembly and interrupt.
    always_comb begin
        istat            = '0;
        istat[IST_MSG0]  = msg_new[0];
        istat[IST_MSG1]  = msg_new[1];
        istat[IST_DBELL] = |dbell;
        istat[IST_POST]  = post_nempty;
        irq              = |(istat & ~imask);
    end
endmodule

// File: rtl/qpmu_ostat.sv
// Module: outbound interrupt status, mask and host interrupt.
// Assumes event inputs are single-cycle pulses. Sticky bits are cleared by
// writing 1, and a set wins over a clear in the same cycle.
module qpmu_ostat
    import qpmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_nempty,
    input  logic             omsg_evt,
    input  logic             ovf_evt,
    input  logic             w1c_we,
    input  logic             mask_we,
    input  logic [OST_W-1:0] wdata,
    output logic [OST_W-1:0] stat,
    output logic [OST_W-1:0] mask,
    output logic             irq
);
    logic omsg_q, ovf_q;

    // Sticky event bits with write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            omsg_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            omsg_q <= omsg_evt | (omsg_q & ~(w1c_we & wdata[OST_OMSG]));
            ovf_q  <= ovf_evt  | (ovf_q  & ~(w1c_we & wdata[OST_OVF]));
        end
    end

    // Outbound mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (mask_we) begin
            mask <= wdata;
        end
    end

    // Status assembly and masked interrupt.
    always_comb begin
        stat             = '0;
        stat[OST_NEMPTY] = out_nempty;
        stat[OST_OMSG]   = omsg_q;
        stat[OST_OVF]    = ovf_q;
        irq              = |(stat & ~mask);
    end
endmodule

// File: rtl/qpmu_top.sv
// Module: queue-port request messaging unit, top level.
// Decodes the host register window, routes the two queue ports to the free
// list, post queue and completion queue, and collects the status logic.
// Assumes at most one host access per cycle. Read data is registered.
module qpmu_top
    import qpmu_pkg::*;
#(
    parameter int FREE_DEPTH = 8,
    parameter int POST_DEPTH = 4,
    parameter int CMPL_DEPTH = 4,
    parameter int TOK_BASE   = 32'h0000_1000,
    parameter int TOK_STEP   = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_irq,
    output logic              l_ibox_valid,
    output logic [DATA_W-1:0] l_ibox_token,
    input  logic              l_ibox_pop,
    input  logic              l_cmpl_push,
    input  logic [DATA_W-1:0] l_cmpl_token,
    output logic [DATA_W-1:0] l_imsg0,
    output logic [DATA_W-1:0] l_imsg1,
    input  logic [1:0]        l_istat_clr,
    input  logic [1:0]        l_omsg_we,
    input  logic [DATA_W-1:0] l_omsg_data,
    output logic [DATA_W-1:0] l_doorbell,
    input  logic [DATA_W-1:0] l_db_clr,
    output logic              l_irq
);
    localparam int FCW = $clog2(FREE_DEPTH + 1);
    localparam int PCW = $clog2(POST_DEPTH + 1);
    localparam int CCW = $clog2(CMPL_DEPTH + 1);

    logic wr_inq, wr_outq, rd_inq, rd_outq;
    logic free_push, free_empty, free_full;
    logic post_empty, post_full;
    logic out_empty, out_full;
    logic ovf_evt;
    logic [DATA_W-1:0] free_head, out_head, omsg0, omsg1;
    logic [FCW-1:0] free_count;
    logic [PCW-1:0] post_count;
    logic [CCW-1:0] out_count;
    logic [IST_W-1:0] istat, imask;
    logic [OST_W-1:0] ostat, omask;
    logic [DATA_W-1:0] rd_mux;

    // Queue-port decode: one address, separate meaning for read and write.
    assign wr_inq    = h_wr && (h_addr == OFF_INQ);
    assign wr_outq   = h_wr && (h_addr == OFF_OUTQ);
    assign rd_inq    = h_rd && (h_addr == OFF_INQ);
    assign rd_outq   = h_rd && (h_addr == OFF_OUTQ);
    assign free_push = wr_outq && !h_wdata[HOST_TOKEN_BIT];

    // Overflow: any accepted-looking push into a full queue.
    assign ovf_evt = (free_push && free_full) || (wr_inq && post_full) ||
                     (l_cmpl_push && out_full);

    qpmu_fifo #(
        .W(DATA_W), .DEPTH(FREE_DEPTH), .INIT_FULL(1'b1),
        .INIT_BASE(TOK_BASE), .INIT_STEP(TOK_STEP)
    ) u_free (
        .clk(clk), .rst_n(rst_n),
        .push(free_push), .push_data(h_wdata),
        .pop(rd_inq), .head(free_head),
        .empty(free_empty), .full(free_full), .count(free_count)
    );

    qpmu_fifo #(
        .W(DATA_W), .DEPTH(POST_DEPTH), .INIT_FULL(1'b0),
        .INIT_BASE(0), .INIT_STEP(0)
    ) u_post (
        .clk(clk), .rst_n(rst_n),
        .push(wr_inq), .push_data(h_wdata),
        .pop(l_ibox_pop), .head(l_ibox_token),
        .empty(post_empty), .full(post_full), .count(post_count)
    );

    qpmu_fifo #(
        .W(DATA_W), .DEPTH(CMPL_DEPTH), .INIT_FULL(1'b0),
        .INIT_BASE(0), .INIT_STEP(0)
    ) u_cmpl (
        .clk(clk), .rst_n(rst_n),
        .push(l_cmpl_push), .push_data(l_cmpl_token),
        .pop(rd_outq), .head(out_head),
        .empty(out_empty), .full(out_full), .count(out_count)
    );

    assign l_ibox_valid = !post_empty;

    qpmu_msgbox u_msg (
        .clk(clk), .rst_n(rst_n),
        .wr_imsg0(h_wr && (h_addr == OFF_IMSG0)),
        .wr_imsg1(h_wr && (h_addr == OFF_IMSG1)),
        .wr_dbell(h_wr && (h_addr == OFF_DBELL)),
        .wr_imask(h_wr && (h_addr == OFF_IMASK)),
        .wdata(h_wdata),
        .istat_clr(l_istat_clr), .db_clr(l_db_clr),
        .omsg_we(l_omsg_we), .omsg_data(l_omsg_data),
        .post_nempty(!post_empty),
        .imsg0(l_imsg0), .imsg1(l_imsg1),
        .omsg0(omsg0), .omsg1(omsg1),
        .dbell(l_doorbell), .istat(istat), .imask(imask),
        .irq(l_irq)
    );

    qpmu_ostat u_ost (
        .clk(clk), .rst_n(rst_n),
        .out_nempty(!out_empty),
        .omsg_evt(l_omsg_we[0]),
        .ovf_evt(ovf_evt),
        .w1c_we(h_wr && (h_addr == OFF_OSTAT)),
        .mask_we(h_wr && (h_addr == OFF_OMASK)),
        .wdata(h_wdata[OST_W-1:0]),
        .stat(ostat), .mask(omask), .irq(h_irq)
    );

    // Host read data select.
    always_comb begin
        unique case (h_addr)
            OFF_IMSG0: rd_mux = l_imsg0;
            OFF_IMSG1: rd_mux = l_imsg1;
            OFF_OMSG0: rd_mux = omsg0;
            OFF_OMSG1: rd_mux = omsg1;
            OFF_DBELL: rd_mux = l_doorbell;
            OFF_ISTAT: rd_mux = DATA_W'(istat);
            OFF_IMASK: rd_mux = DATA_W'(imask);
            OFF_OSTAT: rd_mux = DATA_W'(ostat);
            OFF_OMASK: rd_mux = DATA_W'(omask);
            OFF_INQ:   rd_mux = free_empty ? EMPTY_TOKEN : free_head;
            OFF_OUTQ:  rd_mux = out_empty  ? EMPTY_TOKEN : out_head;
            default:   rd_mux = '0;
        endcase
    end

    // Registered host read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rdata <= '0;
        end else if (h_rd) begin
            h_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/qpmu_chk.sv
// Checker: temporal properties of the messaging unit, bound to qpmu_top.
module qpmu_chk
    import qpmu_pkg::*;
#(
    parameter int FCW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_wr,
    input logic              h_rd,
    input logic [ADDR_W-1:0] h_addr,
    input logic [DATA_W-1:0] h_wdata,
    input logic [DATA_W-1:0] h_rdata,
    input logic              h_irq,
    input logic              free_empty,
    input logic              free_full,
    input logic [FCW-1:0]    free_count,
    input logic              post_full,
    input logic              out_full,
    input logic              l_ibox_valid,
    input logic              l_cmpl_push,
    input logic [1:0]        l_omsg_we,
    input logic [OST_W-1:0]  ostat,
    input logic [OST_W-1:0]  omask
);
    p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && h_addr == OFF_INQ && free_empty) |=> (h_rdata == EMPTY_TOKEN));

    p_empty_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && h_addr == OFF_INQ && free_empty && !h_wr) |=> free_empty);

    p_post_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == OFF_INQ && !post_full) |=> l_ibox_valid);

    p_host_token_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == OFF_OUTQ && h_wdata[HOST_TOKEN_BIT] && !h_rd)
        |=> $stable(free_count));

    p_free_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == OFF_OUTQ && !h_wdata[HOST_TOKEN_BIT] && free_full)
        |=> ostat[OST_OVF]);

    p_cmpl_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_cmpl_push && out_full) |=> ostat[OST_OVF]);

    p_echo_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        l_omsg_we[0] |=> ostat[OST_OMSG]);

    p_cmpl_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (l_cmpl_push && !out_full && !omask[OST_NEMPTY] &&
         !(h_wr && h_addr == OFF_OMASK)) |=> h_irq);

    p_all_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (omask == '1) |-> !h_irq);
endmodule

bind qpmu_top qpmu_chk #(.FCW(FCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
    .free_empty(free_empty), .free_full(free_full), .free_count(free_count),
    .post_full(post_full), .out_full(out_full), .l_ibox_valid(l_ibox_valid),
    .l_cmpl_push(l_cmpl_push), .l_omsg_we(l_omsg_we),
    .ostat(ostat), .omask(omask)
);

// File: tb/sim_qpmu_top.sv
// Bench: directed scenarios for qpmu_top, one task per scenario.
module sim_qpmu_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        h_wr, h_rd;
    logic [7:0]  h_addr;
    logic [31:0] h_wdata, h_rdata;
    logic        h_irq;
    logic        l_ibox_valid;
    logic [31:0] l_ibox_token;
    logic        l_ibox_pop, l_cmpl_push;
    logic [31:0] l_cmpl_token, l_imsg0, l_imsg1;
    logic [1:0]  l_istat_clr, l_omsg_we;
    logic [31:0] l_omsg_data, l_doorbell, l_db_clr;
    logic        l_irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    qpmu_top u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; h_wr = 0; h_rd = 0; h_addr = '0; h_wdata = '0;
        l_ibox_pop = 0; l_cmpl_push = 0; l_cmpl_token = '0;
        l_istat_clr = '0; l_omsg_we = '0; l_omsg_data = '0; l_db_clr = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        h_wr = 1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_wr = 0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        h_rd = 1; h_addr = a;
        @(negedge clk);
        h_rd = 0;
        d = h_rdata;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 h_irq", 32'(h_irq), 0);
        chk("R1 l_irq", 32'(l_irq), 0);
        chk("R1 ibox_valid", 32'(l_ibox_valid), 0);
        hread(8'h30, rd); chk("R1 ostat", rd, 0);
        hread(8'h24, rd); chk("R1 istat", rd, 0);
        hread(8'h44, rd); chk("R1 cmpl empty", rd, 32'hFFFF_FFFF);
    endtask

    task automatic t_free_list();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            hread(8'h40, rd);
            chk("R2 free token", rd, 32'h1000 + i * 32'h100);
        end
        hread(8'h40, rd); chk("R3 empty free read", rd, 32'hFFFF_FFFF);
        hread(8'h40, rd); chk("R3 empty unchanged", rd, 32'hFFFF_FFFF);
        hwrite(8'h44, 32'h8000_0040);
        hread(8'h40, rd); chk("R6 host token discarded", rd, 32'hFFFF_FFFF);
        hread(8'h30, rd); chk("R6 no overflow", rd, 0);
        hwrite(8'h44, 32'h0000_1300);
        hread(8'h40, rd); chk("R6 token returned", rd, 32'h1300);
    endtask

    task automatic t_free_overflow();
        do_reset();
        for (int i = 0; i < 8; i++) hread(8'h40, rd);
        for (int i = 0; i < 8; i++) hwrite(8'h44, 32'h2000 + i);
        chk("R7 no irq before", 32'(h_irq), 0);
        hwrite(8'h44, 32'h0000_3000);
        chk("R7 overflow irq", 32'(h_irq), 1);
        hread(8'h30, rd); chk("R7 ostat ovf", rd, 32'h4);
        hread(8'h40, rd); chk("R7 first kept", rd, 32'h2000);
        hwrite(8'h30, 32'h4);
        hread(8'h30, rd); chk("R9 w1c ovf", rd, 0);
        chk("R10 irq cleared", 32'(h_irq), 0);
    endtask

    task automatic t_post();
        do_reset();
        hwrite(8'h40, 32'h8000_0040);
        chk("R4 valid", 32'(l_ibox_valid), 1);
        chk("R4 token", l_ibox_token, 32'h8000_0040);
        chk("R11 post raises l_irq", 32'(l_irq), 1);
        hwrite(8'h40, 32'h1200);
        hwrite(8'h40, 32'h1300);
        hwrite(8'h40, 32'h1400);
        hwrite(8'h40, 32'h1500);
        hread(8'h30, rd); chk("R7 post overflow", rd, 32'h4);
        l_ibox_pop = 1; @(negedge clk); l_ibox_pop = 0;
        chk("R4 order", l_ibox_token, 32'h1200);
        for (int i = 0; i < 3; i++) begin
            l_ibox_pop = 1; @(negedge clk); l_ibox_pop = 0;
        end
        chk("R4 drained", 32'(l_ibox_valid), 0);
        chk("R11 l_irq drop", 32'(l_irq), 0);
    endtask

    task automatic t_complete();
        do_reset();
        l_cmpl_push = 1; l_cmpl_token = 32'hA;
        @(negedge clk);
        l_cmpl_token = 32'hB;
        @(negedge clk);
        l_cmpl_push = 0;
        chk("R10 cmpl irq", 32'(h_irq), 1);
        hread(8'h30, rd); chk("R9 nempty", rd, 32'h1);
        hwrite(8'h30, 32'h1);
        hread(8'h30, rd); chk("R9 nempty ignores w1c", rd, 32'h1);
        hread(8'h44, rd); chk("R5 first", rd, 32'hA);
        hread(8'h44, rd); chk("R5 second", rd, 32'hB);
        hread(8'h44, rd); chk("R3 cmpl empty", rd, 32'hFFFF_FFFF);
        chk("R10 irq low", 32'(h_irq), 0);
        hwrite(8'h34, 32'h1);
        l_cmpl_push = 1; l_cmpl_token = 32'hC; @(negedge clk); l_cmpl_push = 0;
        chk("R10 masked", 32'(h_irq), 0);
        hread(8'h34, rd); chk("R12 omask readback", rd, 32'h1);
        hwrite(8'h34, 32'h0);
        chk("R10 unmasked", 32'(h_irq), 1);
        hread(8'h44, rd); chk("R5 third", rd, 32'hC);
    endtask

    task automatic t_message();
        do_reset();
        hwrite(8'h10, 32'h0000_0055);
        hwrite(8'h14, 32'h0000_0077);
        chk("R8 imsg0", l_imsg0, 32'h55);
        chk("R8 imsg1", l_imsg1, 32'h77);
        chk("R11 msg l_irq", 32'(l_irq), 1);
        hread(8'h24, rd); chk("R8 istat", rd, 32'h3);
        hread(8'h10, rd); chk("R12 imsg0 readback", rd, 32'h55);
        l_istat_clr = 2'b11; @(negedge clk); l_istat_clr = '0;
        chk("R8 cleared", 32'(l_irq), 0);
        l_omsg_we = 2'b01; l_omsg_data = 32'h55; @(negedge clk); l_omsg_we = '0;
        chk("R8 echo irq", 32'(h_irq), 1);
        hread(8'h18, rd); chk("R8 omsg0", rd, 32'h55);
        hread(8'h30, rd); chk("R9 omsg bit", rd, 32'h2);
        hwrite(8'h30, 32'h2);
        chk("R9 omsg w1c", 32'(h_irq), 0);
        l_omsg_we = 2'b10; l_omsg_data = 32'h99; @(negedge clk); l_omsg_we = '0;
        hread(8'h1C, rd); chk("R8 omsg1", rd, 32'h99);
        chk("R8 omsg1 no irq", 32'(h_irq), 0);
    endtask

    task automatic t_doorbell();
        do_reset();
        hwrite(8'h20, 32'h3);
        hwrite(8'h20, 32'h4);
        chk("R11 doorbell or", l_doorbell, 32'h7);
        hread(8'h24, rd); chk("R11 istat db", rd, 32'h4);
        hwrite(8'h28, 32'h4);
        chk("R11 masked", 32'(l_irq), 0);
        hread(8'h28, rd); chk("R12 imask readback", rd, 32'h4);
        hwrite(8'h28, 32'h0);
        chk("R11 unmasked", 32'(l_irq), 1);
        l_db_clr = 32'h5; @(negedge clk); l_db_clr = '0;
        chk("R11 partial clear", l_doorbell, 32'h2);
        hread(8'h20, rd); chk("R12 doorbell readback", rd, 32'h2);
        hread(8'h08, rd); chk("R12 unmapped", rd, 0);
        hread(8'h2C, rd); chk("R12 unmapped 2c", rd, 0);
    endtask

    initial begin
        rst_n = 0;
        t_reset();
        t_free_list();
        t_free_overflow();
        t_post();
        t_complete();
        t_message();
        t_doorbell();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule